// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block runs one string primitive over and over under a repeat prefix. It is loaded with an element count, a source index, a destination index, an accumulator and a zero flag. It then steps through memory one element at a time over a single-port request/ready interface, until the count runs out or, for the comparing primitives, the zero flag leaves the state the prefix asks for. There are five primitives: copy memory to memory, fill memory from the accumulator, load memory into the accumulator, compare two memory elements, and scan memory for the accumulator value.

An interrupt request is sampled before each iteration. When it is seen, the sequencer parks with all of its registers intact. The index registers then point at the next element that has not been processed, and the count reflects only the completed iterations. A resume strobe continues the run from that point. The address-size selector sets the width of the count and index arithmetic. The element size can be 1, 2, 4 or 8 bytes.

Top module: `strRepSeq`

## Requirements
- R1: If the count loaded at `start` is zero, the sequencer makes no memory request, raises `done` with `exitByFlag` low, and leaves the count, indices, accumulator and flag at their loaded values.
- R2: Each completed iteration lowers the count by exactly one. When the new count is zero the run ends with `done` and `exitByFlag` low.
- R3: With a `prefixByte` value other than 8'hF2 (such as 8'hF3), the compare (`opSel`=3) and scan (`opSel`=4) primitives also end the run after any iteration that clears the zero flag. `exitByFlag` is then high.
- R4: With `prefixByte`=8'hF2, compare and scan end the run after any iteration that sets the zero flag. `exitByFlag` is then high.
- R5: Copy (`opSel`=0), fill (`opSel`=1) and load (`opSel`=2) end only on the count, under either prefix value, and never change the zero flag.
- R6: When `irq` is high as an iteration is about to begin, no access starts. `parked` rises, the indices point at the next element and the count keeps its value from after the last completed iteration. A `resume` pulse then continues the run to its normal end.
- R7: `addrSize` 0, 1 and 2 select 16-, 32- and 64-bit count and index registers. Loaded values are truncated to that width, and index and count arithmetic wraps modulo that width.
- R8: `sizeSel` 0 to 3 selects 1, 2, 4 or 8 byte elements, and indices step forward by that many bytes. Fill writes the low bytes of the accumulator, load replaces only the low bytes of the accumulator, and scan compares only the low bytes.
- R9: When an iteration both exhausts the count and meets the flag condition, the count takes priority and `exitByFlag` is low.
- R10: At most one access is outstanding. `memReq` with its address and write enable stays stable until `memReady`. A compare reads the source element first and the destination element second.
- R11: `done` is a single-cycle pulse, `busy` is high from the cycle after `start` until the run ends or parks, and `memReq` is never high outside `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load operands and begin a run (only while not busy) |
| resume | input | 1 | Continue a parked run |
| irq | input | 1 | Interrupt request, sampled before each iteration |
| opSel | input | 3 | Primitive: 0 copy, 1 fill, 2 load, 3 compare, 4 scan |
| prefixByte | input | 8 | 8'hF2 repeat-while-not-equal, otherwise repeat / repeat-while-equal |
| sizeSel | input | 2 | Element size, 1 << sizeSel bytes |
| addrSize | input | 2 | 0: 16-bit, 1: 32-bit, 2: 64-bit count and indices |
| countIn | input | XLEN | Initial element count |
| srcIn | input | XLEN | Initial source index |
| dstIn | input | XLEN | Initial destination index |
| accIn | input | 64 | Initial accumulator |
| zfIn | input | 1 | Initial zero flag |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | XLEN | Byte address of the element |
| memSize | output | 2 | Element size code of the access |
| memWdata | output | 64 | Write data, little-endian in the low bytes |
| memReady | input | 1 | Access accepted / read data valid this cycle |
| memRdata | input | 64 | Read data, little-endian in the low bytes |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| exitByFlag | output | 1 | Last run ended on the flag condition |
| parked | output | 1 | Run suspended by an interrupt, awaiting resume |
| countOut | output | XLEN | Count register |
| srcOut | output | XLEN | Source index register |
| dstOut | output | XLEN | Destination index register |
| accOut | output | 64 | Accumulator |
| zfOut | output | 1 | Zero flag |

## Verification
The hardest situation to reach from the ports is an interrupt that lands exactly between two iterations of a copy, so that the parked state shows the partly advanced indices and the reduced count. The bench memory model counts the write grants it hands out. On the grant of the second write it raises `irq`, so the request is seen at the next iteration boundary. The test then pulses `resume` and checks that the run finishes with the full copy in memory. A second hard corner is an iteration that meets both exit conditions at once. A one-element scan whose first byte matches forces that case.

// File: rtl/strRepPkg.sv
package strRepPkg;
  localparam int ELEM_MAX_BYTES = 8;
  localparam int DATA_W = 8 * ELEM_MAX_BYTES;

  typedef enum logic [2:0] {
    OP_MOVE = 3'd0,
    OP_FILL = 3'd1,
    OP_LOAD = 3'd2,
    OP_CMP  = 3'd3,
    OP_SCAN = 3'd4
  } strOp_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_ACC1,
    S_ACC2,
    S_STEP
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // take operands from the ports
    logic capTmp;   // hold read data for a later write or compare
    logic loadAcc;  // merge read data into accumulator low lanes
    logic cmpAcc;   // flag from read data against accumulator
    logic cmpTmp;   // flag from read data against held element
    logic step;     // count down and advance indices
    logic useDst;   // address from destination index
  } dpStrobe_t;
endpackage

// File: rtl/strRepDatapath.sv
module strRepDatapath
  import strRepPkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [2:0]          opSel,
  input  logic [7:0]          prefixByte,
  input  logic [1:0]          sizeSel,
  input  logic [1:0]          addrSize,
  input  logic [XLEN-1:0]     countIn,
  input  logic [XLEN-1:0]     srcIn,
  input  logic [XLEN-1:0]     dstIn,
  input  logic [DATA_W-1:0]   accIn,
  input  logic                zfIn,
  input  logic [DATA_W-1:0]   memRdata,
  output strOp_e              op,
  output logic                whileNe,
  output logic                cntZero,
  output logic                cntOne,
  output logic                zf,
  output logic [XLEN-1:0]     countOut,
  output logic [XLEN-1:0]     srcOut,
  output logic [XLEN-1:0]     dstOut,
  output logic [DATA_W-1:0]   accOut,
  output logic [XLEN-1:0]     memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [1:0]          memSize
);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  logic [XLEN-1:0]   cntQ, srcQ, dstQ;
  logic [DATA_W-1:0] accQ, tmpQ;
  logic              zfQ, neQ;
  strOp_e            opQ;
  logic [1:0]        szQ, aszQ;

  function automatic logic [XLEN-1:0] widthMask(input logic [1:0] asz);
    logic [XLEN-1:0] m;
    m = '1;
    if (asz == 2'd0) m = XLEN'(16'hFFFF);
    else if (asz == 2'd1) m = XLEN'(32'hFFFF_FFFF);
    return m;
  endfunction

  logic [XLEN-1:0] runMask, loadMask, stride;
  assign runMask  = widthMask(aszQ);
  assign loadMask = widthMask(addrSize);
  assign stride   = ONE << szQ;

  // byte lanes covered by the current element size
  logic [DATA_W-1:0] laneMask;
  for (genvar b = 0; b < ELEM_MAX_BYTES; b++) begin : g_lane
    assign laneMask[8*b +: 8] = (b < (1 << szQ)) ? 8'hFF : 8'h00;
  end

  logic advSrc, advDst;
  assign advSrc = (opQ == OP_MOVE) || (opQ == OP_LOAD) || (opQ == OP_CMP);
  assign advDst = (opQ == OP_MOVE) || (opQ == OP_FILL) || (opQ == OP_CMP) || (opQ == OP_SCAN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      srcQ <= '0;
      dstQ <= '0;
      accQ <= '0;
      tmpQ <= '0;
      zfQ  <= 1'b0;
      neQ  <= 1'b0;
      opQ  <= OP_MOVE;
      szQ  <= 2'd0;
      aszQ <= 2'd0;
    end else begin
      if (strb.load) begin
        cntQ <= countIn & loadMask;
        srcQ <= srcIn & loadMask;
        dstQ <= dstIn & loadMask;
        accQ <= accIn;
        zfQ  <= zfIn;
        neQ  <= (prefixByte == 8'hF2);
        opQ  <= strOp_e'(opSel);
        szQ  <= sizeSel;
        aszQ <= addrSize;
      end
      if (strb.capTmp)  tmpQ <= memRdata;
      if (strb.loadAcc) accQ <= (accQ & ~laneMask) | (memRdata & laneMask);
      if (strb.cmpAcc)  zfQ  <= ((memRdata ^ accQ) & laneMask) == '0;
      if (strb.cmpTmp)  zfQ  <= ((memRdata ^ tmpQ) & laneMask) == '0;
      if (strb.step) begin
        cntQ <= (cntQ - ONE) & runMask;
        if (advSrc) srcQ <= (srcQ + stride) & runMask;
        if (advDst) dstQ <= (dstQ + stride) & runMask;
      end
    end
  end

  assign op       = opQ;
  assign whileNe  = neQ;
  assign cntZero  = (cntQ == '0);
  assign cntOne   = (cntQ == ONE);
  assign zf       = zfQ;
  assign countOut = cntQ;
  assign srcOut   = srcQ;
  assign dstOut   = dstQ;
  assign accOut   = accQ;
  assign memAddr  = strb.useDst ? dstQ : srcQ;
  assign memWdata = (opQ == OP_FILL) ? accQ : tmpQ;
  assign memSize  = szQ;
endmodule

// File: rtl/strRepControl.sv
module strRepControl
  import strRepPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      resume,
  input  logic      irq,
  input  logic      memReady,
  input  strOp_e    op,
  input  logic      whileNe,
  input  logic      cntZero,
  input  logic      cntOne,
  input  logic      zf,
  output dpStrobe_t strb,
  output logic      memReq,
  output logic      memWe,
  output logic      busy,
  output logic      done,
  output logic      exitByFlag,
  output logic      parked
);
  seqState_e stateQ, stateNxt;
  logic doneQ, doneNxt, flagQ, flagNxt, parkQ, parkSet, parkClr;
  logic isCmp, isScan, twoAcc, flagStop;

  assign isCmp    = (op == OP_CMP);
  assign isScan   = (op == OP_SCAN);
  assign twoAcc   = (op == OP_MOVE) || isCmp;
  assign flagStop = (isCmp || isScan) && (whileNe ? zf : !zf);

  always_comb begin
    strb     = '0;
    stateNxt = stateQ;
    memReq   = 1'b0;
    memWe    = 1'b0;
    doneNxt  = 1'b0;
    flagNxt  = flagQ;
    parkSet  = 1'b0;
    parkClr  = 1'b0;
    case (stateQ)
      S_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          parkClr   = 1'b1;
          stateNxt  = S_CHECK;
        end else if (resume && parkQ) begin
          parkClr  = 1'b1;
          stateNxt = S_CHECK;
        end
      end
      S_CHECK: begin
        if (cntZero) begin
          doneNxt  = 1'b1;
          flagNxt  = 1'b0;
          stateNxt = S_IDLE;
        end else if (irq) begin
          parkSet  = 1'b1;
          stateNxt = S_IDLE;
        end else begin
          stateNxt = S_ACC1;
        end
      end
      S_ACC1: begin
        memReq      = 1'b1;
        memWe       = (op == OP_FILL);
        strb.useDst = (op == OP_FILL) || isScan;
        if (memReady) begin
          strb.capTmp  = twoAcc;
          strb.loadAcc = (op == OP_LOAD);
          strb.cmpAcc  = isScan;
          stateNxt     = twoAcc ? S_ACC2 : S_STEP;
        end
      end
      S_ACC2: begin
        memReq      = 1'b1;
        memWe       = (op == OP_MOVE);
        strb.useDst = 1'b1;
        if (memReady) begin
          strb.cmpTmp = isCmp;
          stateNxt    = S_STEP;
        end
      end
      S_STEP: begin
        strb.step = 1'b1;
        if (cntOne) begin
          doneNxt  = 1'b1;
          flagNxt  = 1'b0;
          stateNxt = S_IDLE;
        end else if (flagStop) begin
          doneNxt  = 1'b1;
          flagNxt  = 1'b1;
          stateNxt = S_IDLE;
        end else begin
          stateNxt = S_CHECK;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      doneQ  <= 1'b0;
      flagQ  <= 1'b0;
      parkQ  <= 1'b0;
    end else begin
      stateQ <= stateNxt;
      doneQ  <= doneNxt;
      flagQ  <= flagNxt;
      if (parkSet) parkQ <= 1'b1;
      else if (parkClr) parkQ <= 1'b0;
    end
  end

  assign busy       = (stateQ != S_IDLE);
  assign done       = doneQ;
  assign exitByFlag = flagQ;
  assign parked     = parkQ;
endmodule

// File: rtl/strRepSeq.sv
module strRepSeq
  import strRepPkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              resume,
  input  logic              irq,
  input  logic [2:0]        opSel,
  input  logic [7:0]        prefixByte,
  input  logic [1:0]        sizeSel,
  input  logic [1:0]        addrSize,
  input  logic [XLEN-1:0]   countIn,
  input  logic [XLEN-1:0]   srcIn,
  input  logic [XLEN-1:0]   dstIn,
  input  logic [63:0]       accIn,
  input  logic              zfIn,
  output logic              memReq,
  output logic              memWe,
  output logic [XLEN-1:0]   memAddr,
  output logic [1:0]        memSize,
  output logic [63:0]       memWdata,
  input  logic              memReady,
  input  logic [63:0]       memRdata,
  output logic              busy,
  output logic              done,
  output logic              exitByFlag,
  output logic              parked,
  output logic [XLEN-1:0]   countOut,
  output logic [XLEN-1:0]   srcOut,
  output logic [XLEN-1:0]   dstOut,
  output logic [63:0]       accOut,
  output logic              zfOut
);
  dpStrobe_t strb;
  strOp_e    op;
  logic      whileNe, cntZero, cntOne, zf;

  strRepControl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .resume(resume), .irq(irq),
    .memReady(memReady), .op(op), .whileNe(whileNe), .cntZero(cntZero),
    .cntOne(cntOne), .zf(zf), .strb(strb), .memReq(memReq), .memWe(memWe),
    .busy(busy), .done(done), .exitByFlag(exitByFlag), .parked(parked)
  );

  strRepDatapath #(.XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opSel(opSel), .prefixByte(prefixByte),
    .sizeSel(sizeSel), .addrSize(addrSize), .countIn(countIn), .srcIn(srcIn),
    .dstIn(dstIn), .accIn(accIn), .zfIn(zfIn), .memRdata(memRdata), .op(op),
    .whileNe(whileNe), .cntZero(cntZero), .cntOne(cntOne), .zf(zf),
    .countOut(countOut), .srcOut(srcOut), .dstOut(dstOut), .accOut(accOut),
    .memAddr(memAddr), .memWdata(memWdata), .memSize(memSize)
  );

  assign zfOut = zf;
endmodule

// File: rtl/strRepSeqChk.sv
module strRepSeqChk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            done,
  input logic            exitByFlag,
  input logic            parked,
  input logic            memReq,
  input logic            memReady,
  input logic            memWe,
  input logic [XLEN-1:0] memAddr,
  input logic [XLEN-1:0] countOut
);
  // R10: a pending request holds its address and direction
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWe));

  // R11: completion lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: no memory traffic outside a run
  p_req_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R9: a flag exit never coincides with an empty count
  p_flag_exit_r9: assert property (@(posedge clk) disable iff (!rstN)
    done && exitByFlag |-> countOut != '0);

  // R2: a count exit leaves the count at zero
  p_count_exit_r2: assert property (@(posedge clk) disable iff (!rstN)
    done && !exitByFlag |-> countOut == '0);

  // R2: during a run the count only moves down by one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) && (countOut != $past(countOut)) |-> countOut == $past(countOut) - 1'b1);

  // R6: a parked run is quiet
  p_park_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    parked |-> !memReq && !busy);
endmodule

bind strRepSeq strRepSeqChk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .exitByFlag(exitByFlag),
  .parked(parked), .memReq(memReq), .memReady(memReady), .memWe(memWe),
  .memAddr(memAddr), .countOut(countOut)
);

// File: tb/tb_strRepSeq.sv
`timescale 1ns/1ps
module tb_strRepSeq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 0, resume = 0, irq = 0;
  logic [2:0] opSel = 0;
  logic [7:0] prefixByte = 8'hF3;
  logic [1:0] sizeSel = 0, addrSize = 0;
  logic [63:0] countIn = 0, srcIn = 0, dstIn = 0, accIn = 0;
  logic zfIn = 0;
  logic memReq, memWe, memReady = 0;
  logic [63:0] memAddr, memWdata, memRdata = 0;
  logic [1:0] memSize;
  logic busy, done, exitByFlag, parked, zfOut;
  logic [63:0] countOut, srcOut, dstOut, accOut;

  always #10 clk = ~clk;

  strRepSeq dut (
    .clk(clk), .rstN(rstN), .start(start), .resume(resume), .irq(irq),
    .opSel(opSel), .prefixByte(prefixByte), .sizeSel(sizeSel), .addrSize(addrSize),
    .countIn(countIn), .srcIn(srcIn), .dstIn(dstIn), .accIn(accIn), .zfIn(zfIn),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata),
    .busy(busy), .done(done), .exitByFlag(exitByFlag), .parked(parked),
    .countOut(countOut), .srcOut(srcOut), .dstOut(dstOut), .accOut(accOut),
    .zfOut(zfOut)
  );

  int checks = 0;
  int errors = 0;

  // byte memory model, low 8 address bits
  logic [7:0] mem [256];
  int grants = 0;
  int wrCount = 0;
  int irqAfter = 0;
  bit stallOn = 0;
  bit stallTog = 0;

  always @(negedge clk) begin
    if (rstN && memReq && !(stallOn && stallTog)) begin
      memReady = 1'b1;
      grants++;
      if (memWe) begin
        for (int b = 0; b < (1 << memSize); b++)
          mem[8'(memAddr + 64'(b))] = memWdata[8*b +: 8];
        wrCount++;
        if (irqAfter != 0 && wrCount == irqAfter) irq = 1'b1;
      end else begin
        for (int b = 0; b < 8; b++)
          memRdata[8*b +: 8] = mem[8'(memAddr + 64'(b))];
      end
    end else begin
      memReady = 1'b0;
    end
    stallTog = ~stallTog;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  pfx;
    logic [1:0]  sz;
    logic [1:0]  asz;
    logic [63:0] cnt;
    logic [63:0] src;
    logic [63:0] dst;
    logic [63:0] acc;
    logic        zfI;
    logic        copy;
    logic [8:0]  plant;
    logic [63:0] eCnt;
    logic [63:0] eSrc;
    logic [63:0] eDst;
    logic [63:0] eAcc;
    logic        eZf;
    logic        eFlag;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R2 copy 3 x 4 bytes, flag kept (also R5)
    '{3'd0, 8'hF3, 2'd2, 2'd1, 64'd3, 64'h10, 64'h80, 64'h0, 1'b1, 1'b0, 9'h0,
      64'd0, 64'h1C, 64'h8C, 64'h0, 1'b1, 1'b0, 4'd2},
    // R8 fill 4 x 2 bytes from accumulator low half-word
    '{3'd1, 8'hF3, 2'd1, 2'd1, 64'd4, 64'h10, 64'h40, 64'hBEEF, 1'b0, 1'b0, 9'h0,
      64'd0, 64'h10, 64'h48, 64'hBEEF, 1'b0, 1'b0, 4'd8},
    // R8 load 2 x 8 bytes
    '{3'd2, 8'hF3, 2'd3, 2'd1, 64'd2, 64'h20, 64'h90, 64'h0, 1'b1, 1'b0, 9'h0,
      64'd0, 64'h30, 64'h90, 64'h2F2E2D2C2B2A2928, 1'b1, 1'b0, 4'd8},
    // R3 compare while equal, mismatch on 4th byte
    '{3'd3, 8'hF3, 2'd0, 2'd1, 64'd10, 64'h0, 64'h60, 64'h0, 1'b1, 1'b1, 9'h163,
      64'd6, 64'h4, 64'h64, 64'h0, 1'b0, 1'b1, 4'd3},
    // R4 compare while not equal, same region matches at once
    '{3'd3, 8'hF2, 2'd1, 2'd1, 64'd8, 64'h10, 64'h10, 64'h0, 1'b0, 1'b0, 9'h0,
      64'd7, 64'h12, 64'h12, 64'h0, 1'b1, 1'b1, 4'd4},
    // R4 scan while not equal finds 0x35 at 6th byte
    '{3'd4, 8'hF2, 2'd0, 2'd1, 64'd20, 64'h10, 64'h30, 64'h35, 1'b0, 1'b0, 9'h0,
      64'd14, 64'h10, 64'h36, 64'h35, 1'b1, 1'b1, 4'd4},
    // R3 scan while equal, only low byte compared (R8)
    '{3'd4, 8'hF3, 2'd0, 2'd1, 64'd5, 64'h10, 64'h50, 64'hAA50, 1'b0, 1'b0, 9'h0,
      64'd3, 64'h10, 64'h52, 64'hAA50, 1'b0, 1'b1, 4'd3},
    // R2 scan exhausts count without a match
    '{3'd4, 8'hF2, 2'd0, 2'd1, 64'd3, 64'h10, 64'h30, 64'hEE, 1'b1, 1'b0, 9'h0,
      64'd0, 64'h10, 64'h33, 64'hEE, 1'b0, 1'b0, 4'd2},
    // R2 compare equal regions to the end
    '{3'd3, 8'hF3, 2'd2, 2'd1, 64'd2, 64'h0, 64'h60, 64'h0, 1'b0, 1'b1, 9'h0,
      64'd0, 64'h8, 64'h68, 64'h0, 1'b1, 1'b0, 4'd2},
    // R9 match and empty count together
    '{3'd4, 8'hF2, 2'd0, 2'd1, 64'd1, 64'h10, 64'h30, 64'h30, 1'b0, 1'b0, 9'h0,
      64'd0, 64'h10, 64'h31, 64'h30, 1'b1, 1'b0, 4'd9},
    // R1 zero count, flag untouched
    '{3'd3, 8'hF3, 2'd0, 2'd1, 64'd0, 64'h10, 64'h20, 64'h0, 1'b1, 1'b0, 9'h0,
      64'd0, 64'h10, 64'h20, 64'h0, 1'b1, 1'b0, 4'd1},
    // R7 16-bit count truncation and index wrap
    '{3'd2, 8'hF3, 2'd1, 2'd0, 64'h10002, 64'hFFFE, 64'h90, 64'h0, 1'b0, 1'b0, 9'h0,
      64'd0, 64'h2, 64'h90, 64'h0100, 1'b0, 1'b0, 4'd7},
    // R7 64-bit index wrap on fill
    '{3'd1, 8'hF3, 2'd3, 2'd2, 64'd1, 64'h10, 64'hFFFF_FFFF_FFFF_FFF8, 64'h1122334455667788, 1'b0, 1'b0, 9'h0,
      64'd0, 64'h10, 64'h0, 64'h1122334455667788, 1'b0, 1'b0, 4'd7},
    // R5 copy under F2 with flag set still runs to the count
    '{3'd0, 8'hF2, 2'd0, 2'd1, 64'd2, 64'h10, 64'hA0, 64'h0, 1'b1, 1'b0, 9'h0,
      64'd0, 64'h12, 64'hA2, 64'h0, 1'b1, 1'b0, 4'd5}
  };

  task automatic memInit();
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
  endtask

  task automatic launch(input logic [2:0] o, input logic [7:0] p, input logic [1:0] s,
                        input logic [1:0] a, input logic [63:0] c, input logic [63:0] sr,
                        input logic [63:0] ds, input logic [63:0] ac, input logic z);
    @(negedge clk);
    opSel = o; prefixByte = p; sizeSel = s; addrSize = a;
    countIn = c; srcIn = sr; dstIn = ds; accIn = ac; zfIn = z;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitFor(input bit wantPark, output bit ok);
    ok = 0;
    for (int t = 0; t < 2000; t++) begin
      if (wantPark ? parked : done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    bit ok;
    string tag;
    memInit();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "busy at reset", 64'(busy), 64'd0);
    chk("R11", "done at reset", 64'(done), 64'd0);
    chk("R11", "memReq at reset", 64'(memReq), 64'd0);
    chk("R7", "count at reset", countOut, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      tag = $sformatf("R%0d", VECS[v].req);
      memInit();
      if (VECS[v].copy)
        for (int k = 0; k < 64; k++) mem[8'(VECS[v].dst + 64'(k))] = mem[8'(VECS[v].src + 64'(k))];
      if (VECS[v].plant[8]) mem[VECS[v].plant[7:0]] = ~mem[VECS[v].plant[7:0]];
      grants = 0; wrCount = 0; stallOn = v[0];
      launch(VECS[v].op, VECS[v].pfx, VECS[v].sz, VECS[v].asz, VECS[v].cnt,
             VECS[v].src, VECS[v].dst, VECS[v].acc, VECS[v].zfI);
      waitFor(0, ok);
      chk(tag, "completion", 64'(ok), 64'd1);
      chk(tag, "count", countOut, VECS[v].eCnt);
      chk(tag, "source index", srcOut, VECS[v].eSrc);
      chk(tag, "destination index", dstOut, VECS[v].eDst);
      chk(tag, "accumulator", accOut, VECS[v].eAcc);
      chk(tag, "zero flag", 64'(zfOut), 64'(VECS[v].eZf));
      chk(tag, "exit by flag", 64'(exitByFlag), 64'(VECS[v].eFlag));
      if (VECS[v].cnt == 0) chk("R1", "accesses on zero count", 64'(grants), 64'd0);
      if (VECS[v].op == 3'd0)
        for (int k = 0; k < int'(VECS[v].cnt) * (1 << VECS[v].sz); k++)
          chk("R10", "copied byte", 64'(mem[8'(VECS[v].dst + 64'(k))]), 64'(8'(VECS[v].src + 64'(k))));
      if (VECS[v].op == 3'd1)
        for (int k = 0; k < int'(VECS[v].cnt) * (1 << VECS[v].sz); k++)
          chk("R8", "filled byte", 64'(mem[8'(VECS[v].dst + 64'(k))]),
              64'(VECS[v].acc[8*(k % (1 << VECS[v].sz)) +: 8]));
      @(negedge clk);
      chk(tag, "done is one cycle", 64'(done), 64'd0);
    end

    // R6 interrupt pending before the first iteration
    stallOn = 0; memInit(); grants = 0; wrCount = 0;
    irq = 1'b1;
    launch(3'd0, 8'hF3, 2'd0, 2'd1, 64'd3, 64'h10, 64'hA0, 64'h0, 1'b0);
    waitFor(1, ok);
    chk("R6", "parked early", 64'(ok), 64'd1);
    chk("R6", "early count", countOut, 64'd3);
    chk("R6", "early source", srcOut, 64'h10);
    chk("R6", "early accesses", 64'(grants), 64'd0);
    irq = 1'b0;

    // R6 interrupt raised after the second copied element
    memInit(); grants = 0; wrCount = 0; irqAfter = 2;
    launch(3'd0, 8'hF3, 2'd0, 2'd1, 64'd6, 64'h10, 64'hA0, 64'h0, 1'b0);
    waitFor(1, ok);
    chk("R6", "parked mid-run", 64'(ok), 64'd1);
    chk("R6", "parked count", countOut, 64'd4);
    chk("R6", "parked source", srcOut, 64'h12);
    chk("R6", "parked destination", dstOut, 64'hA2);
    chk("R6", "busy while parked", 64'(busy), 64'd0);
    irqAfter = 0;
    irq = 1'b0;
    @(negedge clk);
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    waitFor(0, ok);
    chk("R6", "resumed completion", 64'(ok), 64'd1);
    chk("R6", "resumed count", countOut, 64'd0);
    chk("R6", "resumed source", srcOut, 64'h16);
    chk("R6", "resumed destination", dstOut, 64'hA6);
    chk("R6", "parked cleared", 64'(parked), 64'd0);
    for (int k = 0; k < 6; k++)
      chk("R6", "copied byte after resume", 64'(mem[8'hA0 + 8'(k)]), 64'(8'h10 + 8'(k)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule